// File: doc/BRIEF.md
# Parallel Add-Three BCD Adder

This block adds two packed decimal numbers of `N` digits, each digit held as a 4-bit binary coded decimal code, plus an incoming decimal carry. It produces the packed decimal sum and a decimal carry-out. The logic is purely combinational: it has no clock, no reset and no storage, so the outputs follow the inputs through gates alone.

Every digit slice avoids the usual two-step scheme, which forms a full binary sum and then adds six when that sum exceeds nine. The operand bit of weight one goes through a full adder together with the incoming carry, and that adder's sum bit is the result digit's bit 0 as it stands. The three upper bits of the two operands go through three independent half adders. Their sum bits, their carry bits moved up one place, and the full-adder carry are then added into a small intermediate value. That value lies between 0 and 9 and counts units of two. When it is five or more, three is added to it. The corrected 4-bit field sits above the bit-0 sum to give a 5-bit slice result. Its top bit is the decimal carry into the next slice.

Slices are chained from digit 0 upwards. Digit k occupies bits [4k+3:4k] of each operand and of the sum. The carry-in enters digit 0, and the carry-out leaves the top digit. Operand digits above nine are outside the contract.

Top module: `bcd_par_adder`

## Requirements
- R1: Bit 0 of every result digit equals the XOR of bit 0 of both operand digits and that digit's incoming decimal carry.
- R2: The upper three bits of the two operand digits are added place by place by three independent half adders; a sum bit and a carry bit of the same place are never both 1.
- R3: For valid operand digits, the intermediate upper value (half-adder sums + half-adder carries shifted up one place + full-adder carry) is between 0 and 9.
- R4: An intermediate value of 5 or more gets 3 added, a smaller one passes unchanged, so the corrected upper field is never 5, 6 or 7; upper bits 100 and 100 with full-adder carry 1 give the field 1100 (9 + 9 + carry-in 1 = digit 9, carry-out 1).
- R5: The 5-bit slice result is {corrected field, bit-0 sum}; its top bit is the decimal carry-out and its low four bits are a digit from 0 to 9, with carry*10 + digit = a + b + carry-in.
- R6: The correction depends on the full-adder carry: upper bits 000 and 001 give intermediate 0010 when that carry is 1 (1 + 3 = 4) and 0001 when it is 0 (0 + 2 = 2).
- R7: Digit 0 receives `carry_i`; every slice's carry-out is the next slice's carry-in; the top slice's carry-out is `carry_o` (for example 9999 + 0001 = 0000 with carry-out 1).
- R8: Digit k of the operands and of the sum occupies bits [4k+3:4k]; the digit count `N` is a parameter (default 4); {carry_o, sum_o} is the decimal value of a_i + b_i + carry_i for any valid inputs, with no clock involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 4*N | First packed decimal operand, digit 0 in bits [3:0] |
| b_i | input | 4*N | Second packed decimal operand, digit 0 in bits [3:0] |
| carry_i | input | 1 | Decimal carry into digit 0 |
| sum_o | output | 4*N | Packed decimal sum, digit 0 in bits [3:0] |
| carry_o | output | 1 | Decimal carry out of the top digit |

## Verification
The bench runs every one of the 200 single-digit cases, so any slip in the add-three threshold shows up at once: a threshold of six instead of five would leave sums of 10 and 11 as digits with no carry, and a wrong weight for the half-adder carries would break every case that has two equal upper bits. It targets the 100 + 100 case with the full-adder carry both set and clear, where a missing top bit of the correction loses the carry-out, and the 000 + 001 case, which tells the two carry-dependent paths apart. Long ripple chains such as 9999 + 0000 + 1 and 9999 + 9999 + 1 expose a broken link between slices, and random multi-digit sums are compared against a decimal model, so a digit-placement mix-up would give the wrong number.

// File: rtl/bcdp_pkg.sv
package bcdp_pkg;

    localparam int DIGIT_W = 4;
    localparam int UPPER_W = DIGIT_W - 1;
    localparam int FIX_LIMIT = 5;
    localparam int FIX_ADD   = 3;

    typedef logic [DIGIT_W-1:0] bcd_digit_t;
    typedef logic [UPPER_W-1:0] upper_t;

    typedef struct packed {
        logic       carry;
        bcd_digit_t digit;
    } slice_res_t;

    function automatic logic is_bcd(input bcd_digit_t d);
        return (d <= bcd_digit_t'(9));
    endfunction

endpackage

// File: rtl/bcd_lsb_fa.sv
module bcd_lsb_fa (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);
    logic half_x;

    always_comb begin
        half_x = a_i ^ b_i;
        s_o    = half_x ^ c_i;
        c_o    = (a_i & b_i) | (half_x & c_i);
    end

    // R1: sum bit has odd parity with the three inputs
    always_comb begin
        p_fa_parity_r1: assert ((s_o ^ a_i ^ b_i ^ c_i) == 1'b0)
            else $error("full adder sum parity broken");
    end
endmodule

// File: rtl/bcd_upper_ha.sv
module bcd_upper_ha #(
    parameter int W = 3
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] s_o,
    output logic [W-1:0] c_o
);
    for (genvar g = 0; g < W; g++) begin : g_ha
        always_comb begin
            s_o[g] = a_i[g] ^ b_i[g];
            c_o[g] = a_i[g] & b_i[g];
        end
    end

    // R2: a half adder never raises sum and carry together
    always_comb begin
        p_ha_disjoint_r2: assert ((s_o & c_o) == '0)
            else $error("half adder sum and carry both set");
    end
endmodule

// File: rtl/bcd_add3_fix.sv
module bcd_add3_fix
    import bcdp_pkg::*;
(
    input  bcd_digit_t mid_i,
    output bcd_digit_t fix_o
);
    always_comb begin
        if (mid_i >= bcd_digit_t'(FIX_LIMIT))
            fix_o = mid_i + bcd_digit_t'(FIX_ADD);
        else
            fix_o = mid_i;
    end

    // R4: for an in-range intermediate value the field skips 5..7
    always_comb begin
        if (mid_i <= bcd_digit_t'(9)) begin
            p_fix_gap_r4: assert (fix_o < bcd_digit_t'(5) || fix_o >= bcd_digit_t'(8))
                else $error("corrected field landed in the gap: %0d", fix_o);
        end
    end
endmodule

// File: rtl/bcd_digit_slice.sv
module bcd_digit_slice
    import bcdp_pkg::*;
(
    input  bcd_digit_t a_i,
    input  bcd_digit_t b_i,
    input  logic       c_i,
    output bcd_digit_t digit_o,
    output logic       c_o
);
    logic       lsb_sum;
    logic       lsb_cry;
    upper_t     ha_sum;
    upper_t     ha_cry;
    bcd_digit_t mid;
    bcd_digit_t fixed;
    slice_res_t res;

    bcd_lsb_fa u_fa (
        .a_i (a_i[0]),
        .b_i (b_i[0]),
        .c_i (c_i),
        .s_o (lsb_sum),
        .c_o (lsb_cry)
    );

    bcd_upper_ha #(.W(UPPER_W)) u_ha (
        .a_i (a_i[DIGIT_W-1:1]),
        .b_i (b_i[DIGIT_W-1:1]),
        .s_o (ha_sum),
        .c_o (ha_cry)
    );

    always_comb begin
        mid = {1'b0, ha_sum} + {ha_cry, 1'b0} + bcd_digit_t'(lsb_cry);
    end

    bcd_add3_fix u_fix (
        .mid_i (mid),
        .fix_o (fixed)
    );

    always_comb begin
        res     = {fixed, lsb_sum};
        digit_o = res.digit;
        c_o     = res.carry;
    end

    // R3 and R5: range of the intermediate value and decimal meaning of the result
    always_comb begin
        if (is_bcd(a_i) && is_bcd(b_i)) begin
            p_mid_range_r3: assert (mid <= bcd_digit_t'(9))
                else $error("intermediate value out of range: %0d", mid);
            p_digit_bcd_r5: assert (is_bcd(digit_o))
                else $error("result digit not decimal: %0d", digit_o);
            p_slice_value_r5: assert ((32'(c_o) * 10 + 32'(digit_o)) ==
                                      (32'(a_i) + 32'(b_i) + 32'(c_i)))
                else $error("slice value wrong");
        end
    end
endmodule

// File: rtl/bcd_par_adder.sv
module bcd_par_adder
    import bcdp_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [4*N-1:0] a_i,
    input  logic [4*N-1:0] b_i,
    input  logic           carry_i,
    output logic [4*N-1:0] sum_o,
    output logic           carry_o
);
    localparam int W = DIGIT_W * N;

    logic [N:0] chain;

    assign chain[0] = carry_i;

    for (genvar k = 0; k < N; k++) begin : g_dig
        bcd_digit_slice u_slice (
            .a_i     (a_i[DIGIT_W*k +: DIGIT_W]),
            .b_i     (b_i[DIGIT_W*k +: DIGIT_W]),
            .c_i     (chain[k]),
            .digit_o (sum_o[DIGIT_W*k +: DIGIT_W]),
            .c_o     (chain[k+1])
        );
    end

    assign carry_o = chain[N];

    // R7: all-nines plus carry-in of one wraps every digit to zero
    always_comb begin
        if (a_i == {(W/4){4'h9}} && b_i == '0 && carry_i) begin
            p_ripple_r7: assert (sum_o == '0 && carry_o)
                else $error("carry did not ripple through all digits");
        end
    end
endmodule

// File: tb/sim_bcd_par_adder.sv
module sim_bcd_par_adder;
    localparam int NDIG = 4;
    localparam int W    = 4 * NDIG;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic [W-1:0] a, b, s;
    logic         ci, co;

    int n_chk  = 0;
    int n_fail = 0;
    logic done = 1'b0;

    bcd_par_adder #(.N(NDIG)) u0 (
        .a_i (a), .b_i (b), .carry_i (ci), .sum_o (s), .carry_o (co)
    );

    function automatic longint dec_val(input logic [W-1:0] v);
        longint r = 0;
        for (int k = NDIG - 1; k >= 0; k--) r = r * 10 + longint'(v[4*k +: 4]);
        return r;
    endfunction

    function automatic logic [W-1:0] to_bcd(input longint v);
        logic [W-1:0] r = '0;
        longint t = v;
        for (int k = 0; k < NDIG; k++) begin
            r[4*k +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    function automatic longint pow10n();
        longint p = 1;
        for (int k = 0; k < NDIG; k++) p = p * 10;
        return p;
    endfunction

    task automatic drive(input logic [W-1:0] av, input logic [W-1:0] bv, input logic cv);
        @(posedge clk);
        #2;
        a = av; b = bv; ci = cv;
        @(negedge clk);
    endtask

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s a=%h b=%h ci=%0d actual=%0h expected=%0h", req, a, b, ci, act, exp);
        end
    endtask

    task automatic check_full(input string req);
        longint tot = dec_val(a) + dec_val(b) + longint'(ci);
        check(req, longint'(s), longint'(to_bcd(tot % pow10n())));
        check(req, longint'(co), longint'(tot >= pow10n()));
    endtask

    // R8: zero in gives zero out
    task automatic t_zero_state();
        drive('0, '0, 1'b0);
        check("R8 zero", longint'({co, s}), 0);
    endtask

    // R1 R3 R4 R5: every single-digit case
    task automatic t_exhaustive_digit();
        for (int x = 0; x < 10; x++)
            for (int y = 0; y < 10; y++)
                for (int c = 0; c < 2; c++) begin
                    drive(W'(x), W'(y), c[0]);
                    check("R5 digit", longint'(s[3:0]), longint'((x + y + c) % 10));
                    check("R5 carry", longint'(s[7:4]), longint'((x + y + c) / 10));
                    check("R1 bit0", longint'(s[0]), longint'(x[0] ^ y[0] ^ c[0]));
                end
    endtask

    // R4 R6: carry-dependent correction corners
    task automatic t_correction_corners();
        drive(W'(4'h9), W'(4'h9), 1'b1);
        check("R4 1100 field", longint'(s[7:0]), 64'h19);
        drive(W'(4'h8), W'(4'h8), 1'b0);
        check("R4 no lsb carry", longint'(s[7:0]), 64'h16);
        drive(W'(4'h1), W'(4'h3), 1'b0);
        check("R6 carry one", longint'(s[7:0]), 64'h04);
        drive(W'(4'h0), W'(4'h2), 1'b0);
        check("R6 carry zero", longint'(s[7:0]), 64'h02);
        drive(W'(4'h4), W'(4'h1), 1'b0);
        check("R4 exactly five", longint'(s[7:0]), 64'h05);
    endtask

    // R7: ripple through all digits
    task automatic t_ripple();
        drive(16'h9999, 16'h0000, 1'b1);
        check("R7 wrap s", longint'(s), 0);
        check("R7 wrap co", longint'(co), 1);
        drive(16'h9999, 16'h0001, 1'b0);
        check_full("R7 plus one");
        drive(16'h9999, 16'h9999, 1'b1);
        check_full("R7 max");
        drive(16'h5000, 16'h4999, 1'b1);
        check_full("R7 exact carry");
    endtask

    // R8: digit placement
    task automatic t_placement();
        drive(16'h0100, 16'h0200, 1'b0);
        check("R8 digit2", longint'(s), 64'h0300);
        drive(16'h0050, 16'h0050, 1'b0);
        check("R8 carry to digit2", longint'(s), 64'h0100);
    endtask

    // R8 R7: random multi-digit sums
    task automatic t_random();
        for (int i = 0; i < 400; i++) begin
            logic [W-1:0] ra, rb;
            for (int k = 0; k < NDIG; k++) begin
                ra[4*k +: 4] = 4'($urandom_range(0, 9));
                rb[4*k +: 4] = 4'($urandom_range(0, 9));
            end
            drive(ra, rb, 1'($urandom_range(0, 1)));
            check_full("R8 random");
        end
    endtask

    initial begin
        a = '0; b = '0; ci = 1'b0;
        repeat (2) @(posedge clk);
        t_zero_state();
        t_exhaustive_digit();
        t_correction_corners();
        t_ripple();
        t_placement();
        t_random();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (190000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule